// File: doc/BRIEF.md
# Eight-channel timer register bank

This block is the register side of a bank of eight down-counting timers. A host reaches it through a plain strobe interface carrying 32-bit aligned words in a 4 KB address window. The window holds sixteen-byte windows with four registers each: the live count, the reload value and two match values. Windows 0 to 2 map channels 0 to 2. Window 3 holds the shared control word and a spare control word. Windows 4 to 8 map channels 3 to 7. All other addresses are holes.

The shared control word gives each channel a four-bit field. The block turns these fields into per-channel enable, clock-select, overflow-interrupt and pulse-mode settings. Enable changes are ordered against the other bits. When a channel is switched on, its configuration is applied first and the enable follows one cycle later. When it is switched off, the enable drops first and the configuration follows one cycle later. Each channel counts down, reloads when it passes zero, and raises a one-cycle interrupt pulse on a match or on reaching zero.

Top module: `tmr_bank`

## Requirements
- R1: Address window w holds channel w for w in 0..2 and channel w-1 for w in 4..8. Within a window, byte offset 0x0 is the count, 0x4 the reload, 0x8 the first match and 0xC the second match. Reload and match values read back as written.
- R2: Offset 0x30 is the shared control word and reads back as written. Channel n uses bits [4n+3:4n]: bit 0 enable, bit 1 external tick select, bit 2 zero-reach interrupt enable, bit 3 pulse mode. The applied settings appear on tmr_en, cfg_ext, cfg_ovf and cfg_pulse.
- R3: Offset 0x34 is a spare word that reads back as written and changes no output.
- R4: Offsets 0x38 and 0x3C, windows above 8, any address with bits [11:8] nonzero, and any address with bits [1:0] nonzero are unmapped. Reads of them return zero, writes to them change nothing, and addr_err is high for one cycle in the cycle after the strobe.
- R5: Read data and rd_valid appear in the cycle after rd_en. rdata is zero when rd_valid is low.
- R6: A control write that sets a channel's enable applies that channel's other bits at the write edge and raises tmr_en one cycle later. On that later edge the count is loaded from the reload value.
- R7: A control write that clears a channel's enable lowers tmr_en at the write edge and applies the other bits one cycle later.
- R8: Pulse mode takes effect only on channels 4 to 7. A control write that sets the pulse bit of any of channels 0 to 3 sets pulse_err, which stays set until reset.
- R9: Reset clears both control words, every channel register, every output setting, irq and pulse_err.
- R10: An enabled channel decrements its count once per clock when bit 1 is clear, or once per cycle with ext_tick high when bit 1 is set. At zero the next step loads the reload value. A disabled channel holds its count.
- R11: A write to the count offset sets the count. A reload write that changes the reload from zero to a nonzero value on an enabled channel also loads the count with that value. A reload write over a nonzero reload leaves the count alone.
- R12: irq[n] pulses for one cycle on the step whose new count equals a nonzero match value. It also pulses on the step that brings a nonzero count to zero while bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address in the window |
| wdata | input | 32 | Write data |
| ext_tick | input | 1 | External count tick for channels in external mode |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rdata is valid |
| addr_err | output | 1 | Previous access hit an unmapped address |
| pulse_err | output | 1 | Sticky flag: pulse mode was requested on a channel without it |
| tmr_en | output | 8 | Applied per-channel enable |
| cfg_ext | output | 8 | Applied per-channel external tick select |
| cfg_ovf | output | 8 | Applied per-channel zero-reach interrupt enable |
| cfg_pulse | output | 8 | Applied per-channel pulse mode |
| irq | output | 8 | Per-channel interrupt pulse |

## Verification
The bench probes the edges of the split map: the first channel above the control window, the last window, and the holes next to the control word. A decoder off by one window would alias a channel onto the control block or lose channel 7. Misaligned and high-bit addresses are written and then the neighbouring registers are read back, so a decoder that drops address bits would show up as a corrupted reload. For the enable ordering, the bench samples the outputs between the two edges of each switch, which catches a design that applies enable and configuration together. The pulse-mode boundary between channels 3 and 4, the reload-from-zero start, and interrupts on a match and on reaching zero are each checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CFG_W = 4;

    // Per-channel field of the shared control word; bit 0 is enable.
    typedef struct packed {
        logic pulse;
        logic ovf;
        logic ext;
        logic en;
    } tmr_cfg_t;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_MATCH1 = 2'd2,
        REG_MATCH2 = 2'd3
    } tmr_reg_e;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int unsigned AW       = 12,
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned CTRL_WIN = 3
) (
    input  logic [AW-1:0]             addr,
    output logic                      ch_hit,
    output logic [$clog2(NUM_CH)-1:0] ch_idx,
    output tmr_reg_e                  reg_sel,
    output logic                      ctrl_hit,
    output logic                      ctrl2_hit,
    output logic                      bad
);
    localparam int unsigned WIN_W = AW - 4;
    localparam int unsigned IDX_W = $clog2(NUM_CH);

    logic [WIN_W-1:0] win;
    logic [1:0]       off;

    assign win     = addr[AW-1:4];
    assign off     = addr[3:2];
    assign reg_sel = tmr_reg_e'(off);

    always_comb begin
        ch_hit    = 1'b0;
        ch_idx    = '0;
        ctrl_hit  = 1'b0;
        ctrl2_hit = 1'b0;
        if (addr[1:0] == 2'b00) begin
            if (win == WIN_W'(CTRL_WIN)) begin
                ctrl_hit  = (off == 2'd0);
                ctrl2_hit = (off == 2'd1);
            end else if (win < WIN_W'(CTRL_WIN)) begin
                ch_hit = 1'b1;
                ch_idx = IDX_W'(win);
            end else if (win <= WIN_W'(NUM_CH)) begin
                ch_hit = 1'b1;
                ch_idx = IDX_W'(win - WIN_W'(1));
            end
        end
        bad = !(ch_hit || ctrl_hit || ctrl2_hit);
    end

endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned PULSE_FIRST = 4,
    localparam int unsigned CTRL_W     = NUM_CH * CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_old,
    input  logic [CTRL_W-1:0] ctrl_new,
    output logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] ext,
    output logic [NUM_CH-1:0] ovf,
    output logic [NUM_CH-1:0] pulse,
    output logic [NUM_CH-1:0] start,
    output logic              pulse_viol
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] ext;
        logic [NUM_CH-1:0] ovf;
        logic [NUM_CH-1:0] pulse;
        logic [NUM_CH-1:0] en_pend;
        logic [NUM_CH-1:0] cfg_pend;
    } seq_st_t;

    seq_st_t  st_d, st_q;
    tmr_cfg_t oc, nc;

    always_comb begin
        st_d       = st_q;
        pulse_viol = 1'b0;
        oc         = '0;
        nc         = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            oc = tmr_cfg_t'(ctrl_old[i*CFG_W +: CFG_W]);
            nc = tmr_cfg_t'(ctrl_new[i*CFG_W +: CFG_W]);
            // second half of an earlier switch
            if (st_q.en_pend[i]) begin
                st_d.en[i]      = 1'b1;
                st_d.en_pend[i] = 1'b0;
            end
            if (st_q.cfg_pend[i]) begin
                st_d.ext[i]      = oc.ext;
                st_d.ovf[i]      = oc.ovf;
                st_d.pulse[i]    = oc.pulse && (i >= PULSE_FIRST);
                st_d.cfg_pend[i] = 1'b0;
            end
            if (ctrl_wr) begin
                if ((i < PULSE_FIRST) && nc.pulse) begin
                    pulse_viol = 1'b1;
                end
                if (oc.en && !nc.en) begin
                    st_d.en[i]       = 1'b0;
                    st_d.en_pend[i]  = 1'b0;
                    st_d.cfg_pend[i] = 1'b1;
                end else begin
                    st_d.ext[i]      = nc.ext;
                    st_d.ovf[i]      = nc.ovf;
                    st_d.pulse[i]    = nc.pulse && (i >= PULSE_FIRST);
                    st_d.cfg_pend[i] = 1'b0;
                    if (!oc.en && nc.en) begin
                        st_d.en_pend[i] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en    = st_q.en;
    assign ext   = st_q.ext;
    assign ovf   = st_q.ovf;
    assign pulse = st_q.pulse;
    assign start = st_q.en_pend;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R6: enable rises only after a pending switch-on cycle
        a_r6_en_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.en[g]) |-> $past(st_q.en_pend[g]));
        // R7: a clearing write removes enable at its own edge
        a_r7_disable_first: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && ctrl_old[g*CFG_W] && !ctrl_new[g*CFG_W]) |=> !st_q.en[g]);
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ext_sel,
    input  logic          ovf_en,
    input  logic          ext_tick,
    input  logic          start,
    input  logic          wr_count,
    input  logic          wr_reload,
    input  logic          wr_match1,
    input  logic          wr_match2,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count,
    output logic [DW-1:0] reload,
    output logic [DW-1:0] match1,
    output logic [DW-1:0] match2,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] count;
        logic [DW-1:0] reload;
        logic [DW-1:0] m1;
        logic [DW-1:0] m2;
        logic          irq;
    } ch_st_t;

    ch_st_t        st_d, st_q;
    logic          step;
    logic [DW-1:0] nxt;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        step     = en && (ext_sel ? ext_tick : 1'b1);
        nxt      = (st_q.count == '0) ? st_q.reload : st_q.count - DW'(1);
        if (wr_reload) st_d.reload = wdata;
        if (wr_match1) st_d.m1     = wdata;
        if (wr_match2) st_d.m2     = wdata;
        if (wr_count) begin
            st_d.count = wdata;
        end else if (start) begin
            st_d.count = st_q.reload;
        end else if (wr_reload && en && (st_q.reload == '0) && (wdata != '0)) begin
            st_d.count = wdata;
        end else if (step) begin
            st_d.count = nxt;
            st_d.irq   = (ovf_en && (st_q.count != '0) && (nxt == '0))
                      || ((st_q.m1 != '0) && (nxt == st_q.m1))
                      || ((st_q.m2 != '0) && (nxt == st_q.m2));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.count;
    assign reload = st_q.reload;
    assign match1 = st_q.m1;
    assign match2 = st_q.m2;
    assign irq    = st_q.irq;

    // R11: a count write lands exactly
    a_r11_count_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> (count == $past(wdata)));
    // R10: a disabled, untouched channel holds its count
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_count && !start) |=> $stable(count));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned CTRL_WIN    = 3,
    parameter int unsigned PULSE_FIRST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_tick,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              addr_err,
    output logic              pulse_err,
    output logic [NUM_CH-1:0] tmr_en,
    output logic [NUM_CH-1:0] cfg_ext,
    output logic [NUM_CH-1:0] cfg_ovf,
    output logic [NUM_CH-1:0] cfg_pulse,
    output logic [NUM_CH-1:0] irq
);
    localparam int unsigned IDX_W  = $clog2(NUM_CH);
    localparam int unsigned CTRL_W = NUM_CH * CFG_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ctrl2;
        logic [DATA_W-1:0] rdata;
        logic              rd_valid;
        logic              err;
        logic              perr;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    logic              ch_hit, ctrl_hit, ctrl2_hit, bad;
    logic [IDX_W-1:0]  ch_idx;
    tmr_reg_e          reg_sel;
    logic              ctrl_wr, pulse_viol;
    logic [NUM_CH-1:0] start;
    logic [DATA_W-1:0] cnt_a [NUM_CH];
    logic [DATA_W-1:0] rld_a [NUM_CH];
    logic [DATA_W-1:0] m1_a  [NUM_CH];
    logic [DATA_W-1:0] m2_a  [NUM_CH];
    logic [DATA_W-1:0] rd_mux;

    tmr_addr_dec #(.AW(ADDR_W), .NUM_CH(NUM_CH), .CTRL_WIN(CTRL_WIN)) u_dec (
        .addr      (addr),
        .ch_hit    (ch_hit),
        .ch_idx    (ch_idx),
        .reg_sel   (reg_sel),
        .ctrl_hit  (ctrl_hit),
        .ctrl2_hit (ctrl2_hit),
        .bad       (bad)
    );

    assign ctrl_wr = wr_en && ctrl_hit;

    tmr_ctrl_seq #(.NUM_CH(NUM_CH), .PULSE_FIRST(PULSE_FIRST)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_old   (st_q.ctrl[CTRL_W-1:0]),
        .ctrl_new   (wdata[CTRL_W-1:0]),
        .en         (tmr_en),
        .ext        (cfg_ext),
        .ovf        (cfg_ovf),
        .pulse      (cfg_pulse),
        .start      (start),
        .pulse_viol (pulse_viol)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr_en && ch_hit && (ch_idx == IDX_W'(g));
        tmr_channel #(.DW(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (tmr_en[g]),
            .ext_sel   (cfg_ext[g]),
            .ovf_en    (cfg_ovf[g]),
            .ext_tick  (ext_tick),
            .start     (start[g]),
            .wr_count  (sel && (reg_sel == REG_COUNT)),
            .wr_reload (sel && (reg_sel == REG_RELOAD)),
            .wr_match1 (sel && (reg_sel == REG_MATCH1)),
            .wr_match2 (sel && (reg_sel == REG_MATCH2)),
            .wdata     (wdata),
            .count     (cnt_a[g]),
            .reload    (rld_a[g]),
            .match1    (m1_a[g]),
            .match2    (m2_a[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (ctrl_hit) begin
            rd_mux = st_q.ctrl;
        end else if (ctrl2_hit) begin
            rd_mux = st_q.ctrl2;
        end else if (ch_hit) begin
            case (reg_sel)
                REG_COUNT:  rd_mux = cnt_a[ch_idx];
                REG_RELOAD: rd_mux = rld_a[ch_idx];
                REG_MATCH1: rd_mux = m1_a[ch_idx];
                default:    rd_mux = m2_a[ch_idx];
            endcase
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        st_d.rdata    = rd_en ? rd_mux : '0;
        st_d.err      = (rd_en || wr_en) && bad;
        st_d.perr     = st_q.perr || pulse_viol;
        if (ctrl_wr) begin
            st_d.ctrl = wdata;
        end
        if (wr_en && ctrl2_hit) begin
            st_d.ctrl2 = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign rd_valid  = st_q.rd_valid;
    assign addr_err  = st_q.err;
    assign pulse_err = st_q.perr;

    // R4: an unmapped read returns zero
    a_r4_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bad) |=> (rdata == '0));
    // R8: the pulse-mode error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_err |=> pulse_err);
    // R5: data is qualified one cycle after the strobe
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ext_tick = 1'b0;
    logic [31:0] rdata;
    logic        rd_valid, addr_err, pulse_err;
    logic [7:0]  tmr_en, cfg_ext, cfg_ovf, cfg_pulse, irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ext_tick(ext_tick), .rdata(rdata), .rd_valid(rd_valid),
        .addr_err(addr_err), .pulse_err(pulse_err), .tmr_en(tmr_en),
        .cfg_ext(cfg_ext), .cfg_ovf(cfg_ovf), .cfg_pulse(cfg_pulse), .irq(irq)
    );

    // {is_read, expect_err, addr[11:0], data[31:0]}
    localparam int NV = 32;
    localparam logic [45:0] VEC [NV] = '{
        {1'b1, 1'b0, 12'h030, 32'h0000_0000},
        {1'b1, 1'b0, 12'h004, 32'h0000_0000},
        {1'b0, 1'b0, 12'h004, 32'h1111_0004},
        {1'b0, 1'b0, 12'h008, 32'h2222_0008},
        {1'b0, 1'b0, 12'h00C, 32'h3333_000C},
        {1'b0, 1'b0, 12'h024, 32'hA5A5_0024},
        {1'b0, 1'b0, 12'h044, 32'h4444_0044},
        {1'b0, 1'b0, 12'h054, 32'h5555_0054},
        {1'b0, 1'b0, 12'h08C, 32'h7777_008C},
        {1'b0, 1'b0, 12'h000, 32'h0000_ABCD},
        {1'b0, 1'b0, 12'h034, 32'hDEAD_BEEF},
        {1'b0, 1'b1, 12'h038, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 12'h03C, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 12'h006, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 12'h090, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 12'h104, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 12'h004, 32'h1111_0004},
        {1'b1, 1'b0, 12'h008, 32'h2222_0008},
        {1'b1, 1'b0, 12'h00C, 32'h3333_000C},
        {1'b1, 1'b0, 12'h024, 32'hA5A5_0024},
        {1'b1, 1'b0, 12'h044, 32'h4444_0044},
        {1'b1, 1'b0, 12'h054, 32'h5555_0054},
        {1'b1, 1'b0, 12'h08C, 32'h7777_008C},
        {1'b1, 1'b0, 12'h000, 32'h0000_ABCD},
        {1'b1, 1'b0, 12'h034, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 12'h038, 32'h0000_0000},
        {1'b1, 1'b1, 12'h03C, 32'h0000_0000},
        {1'b1, 1'b0, 12'h030, 32'h0000_0000},
        {1'b1, 1'b1, 12'h090, 32'h0000_0000},
        {1'b1, 1'b0, 12'h084, 32'h0000_0000},
        {1'b1, 1'b0, 12'h014, 32'h0000_0000},
        {1'b1, 1'b1, 12'h002, 32'h0000_0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = addr_err;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d,
                           output logic v, output logic e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid; e = addr_err;
    endtask

    task automatic tick();
        @(negedge clk);
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        logic v, e;
        do_read(a, d, v, e);
        chk(v && (d == exp), tag, d, exp);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, v1, v2;
        logic v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk((tmr_en == 0) && (cfg_ext == 0) && (irq == 0) && !pulse_err && !rd_valid,
            "R9 reset outputs", {tmr_en, cfg_ext, irq, 7'd0, pulse_err}, 32'd0);

        // vector walk: R1 map, R3 spare word, R4 holes, R5 latency
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][45]) begin
                do_read(VEC[k][43:32], d, v, e);
                chk(v && (d == VEC[k][31:0]) && (e == VEC[k][44]),
                    "R1/R4/R5 read vector", d, VEC[k][31:0]);
            end else begin
                do_write(VEC[k][43:32], VEC[k][31:0], e);
                chk(e == VEC[k][44], "R4 write error flag", {31'd0, e}, {31'd0, VEC[k][44]});
            end
        end

        // R3: spare word changed nothing
        chk((tmr_en == 0) && (cfg_ext == 0) && (cfg_ovf == 0) && (cfg_pulse == 0),
            "R3 spare word no effect", {tmr_en, cfg_ext, cfg_ovf, cfg_pulse}, 32'd0);

        // R6 / R2: ch0 on in external mode
        do_write(12'h030, 32'h0000_0003, e);
        chk(cfg_ext[0] && !tmr_en[0], "R6 config before enable", {cfg_ext, tmr_en}, 32'h0100);
        @(negedge clk);
        chk(tmr_en[0] == 1'b1, "R6 enable one cycle later", {31'd0, tmr_en[0]}, 32'd1);
        rd_chk(12'h030, 32'h0000_0003, "R2 control readback");
        rd_chk(12'h000, 32'h1111_0004, "R6 count loaded from reload");

        // R12 match interrupt, R10 external tick counting
        do_write(12'h000, 32'd5, e);
        do_write(12'h008, 32'd3, e);
        tick();
        chk(irq[0] == 1'b0, "R12 no irq off match", {31'd0, irq[0]}, 32'd0);
        tick();
        chk(irq[0] == 1'b1, "R12 irq on match", {31'd0, irq[0]}, 32'd1);
        @(negedge clk);
        chk(irq[0] == 1'b0, "R12 irq one cycle", {31'd0, irq[0]}, 32'd0);
        rd_chk(12'h000, 32'd3, "R10 ext ticks counted");

        // R7 disable ordering
        do_write(12'h030, 32'h0000_0000, e);
        chk(!tmr_en[0] && cfg_ext[0], "R7 enable drops first", {cfg_ext, tmr_en}, 32'h0100);
        @(negedge clk);
        chk(cfg_ext[0] == 1'b0, "R7 config one cycle later", {31'd0, cfg_ext[0]}, 32'd0);
        tick();
        rd_chk(12'h000, 32'd3, "R10 disabled holds");

        // R8 pulse boundary: ch3 pulse (bit 15) refused, ch4 pulse (bit 19) applied
        chk(pulse_err == 1'b0, "R8 flag clear before", {31'd0, pulse_err}, 32'd0);
        do_write(12'h030, 32'h0008_8000, e);
        chk(cfg_pulse == 8'h10, "R8 pulse only on ch4+", {24'd0, cfg_pulse}, 32'h10);
        chk(pulse_err == 1'b1, "R8 flag set", {31'd0, pulse_err}, 32'd1);

        // R10 internal counting on ch1
        do_write(12'h014, 32'd1000, e);
        do_write(12'h030, 32'h0000_0010, e);
        chk(pulse_err == 1'b1, "R8 flag sticky", {31'd0, pulse_err}, 32'd1);
        repeat (3) @(negedge clk);
        do_read(12'h010, v1, v, e);
        do_read(12'h010, v2, v, e);
        chk((v1 - v2) == 32'd2, "R10 one step per clock", v1 - v2, 32'd2);
        chk((v1 < 32'd1000) && (v1 > 32'd900), "R10 counts from reload", v1, 32'd995);

        // R11 reload-from-zero start on ch6 (window 7)
        do_write(12'h030, 32'h0300_0010, e);
        @(negedge clk);
        rd_chk(12'h070, 32'd0, "R11 zero reload gives zero count");
        do_write(12'h074, 32'd7, e);
        rd_chk(12'h070, 32'd7, "R11 reload from zero starts");
        do_write(12'h074, 32'd9, e);
        rd_chk(12'h070, 32'd7, "R11 nonzero reload leaves count");

        // R12 zero-reach interrupt on ch6
        do_write(12'h070, 32'd2, e);
        do_write(12'h030, 32'h0700_0010, e);
        tick();
        chk(irq[6] == 1'b0, "R12 no irq at 1", {31'd0, irq[6]}, 32'd0);
        tick();
        chk(irq[6] == 1'b1, "R12 irq at zero", {31'd0, irq[6]}, 32'd1);
        tick();
        chk(irq[6] == 1'b0, "R12 no irq on reload", {31'd0, irq[6]}, 32'd0);
        rd_chk(12'h070, 32'd9, "R10 reload after zero");

        // R9 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk((tmr_en == 0) && (cfg_ovf == 0) && !pulse_err && (irq == 0),
            "R9 reset clears outputs", {tmr_en, cfg_ovf, irq, 7'd0, pulse_err}, 32'd0);
        rd_chk(12'h004, 32'd0, "R9 reset clears reload");
        rd_chk(12'h030, 32'd0, "R9 reset clears control");
        rd_chk(12'h034, 32'd0, "R9 reset clears spare");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule